// File: doc/BRIEF.md
# Partitioned Six-Step Up/Down Counter

This block counts through six positions, 0 to 5, in either direction, and wraps at both ends. It is not built as one flat state register. Two small sub-machines share the work, and each one has two flip-flops. The low segment owns counts 0, 1 and 2. The high segment owns counts 3, 4 and 5. Each segment also has one parking code in which it owns no count.

Only one segment is live at any time. The other segment sits in its parking code and watches the live one. When the count crosses from one segment's range into the other's, control passes across. The segment that gives up control parks itself. The segment that receives control leaves its parking code and enters at the correct end of its range, in the same clock edge.

Two request inputs steer the count. One requests a step up and the other requests a step down. If both are low, or both are high, the count stays where it is. The output is the count of the live segment, given as a binary number.

Top module: `ud6_counter`

## Requirements
- R1: While rst_ni is low, and after its release until the first stepping edge, count_o is 0. The low segment is live at count 0 and the high segment is parked.
- R2: With up_i=1 and down_i=0, count_o rises by one on each clock edge. After 5 it goes to 0.
- R3: With down_i=1 and up_i=0, count_o falls by one on each clock edge. After 0 it goes to 5.
- R4: When up_i and down_i are equal (both 0 or both 1), count_o keeps its value across the edge.
- R5: At every cycle after reset exactly one segment is live (not parked).
- R6: Stepping up from 2 parks the low segment and starts the high segment at 3. Stepping up from 5 parks the high segment and starts the low segment at 0.
- R7: Stepping down from 3 parks the high segment and starts the low segment at 2. Stepping down from 0 parks the low segment and starts the high segment at 5.
- R8: count_o never leaves the range 0 to 5. It equals the live segment's local position, plus 3 when the high segment is live.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | Request one step up |
| down_i | input | 1 | Request one step down |
| count_o | output | 3 | Current count, 0 to 5 |

## Verification
The block has no free parameters, so the bench builds the single fixed six-position form. That single form still contains every segment crossing: 2 to 3 and 5 to 0 going up, and 3 to 2 and 0 to 5 going down. Directed walks drive the count through all four crossings and through runs of both hold codes. A long random sequence that favours stepping then reaches handoffs in both directions, including a reversal right after a segment has just taken control.

// File: rtl/ud6_pkg.sv
package ud6_pkg;
  localparam int unsigned SEG_LEN = 3;
  localparam int unsigned POS_W   = 2;
  localparam int unsigned CNT_W   = 3;

  // local position within a segment; PARK = segment owns no count
  typedef enum logic [POS_W-1:0] {
    POS0 = 2'b00,
    POS1 = 2'b01,
    POS2 = 2'b10,
    PARK = 2'b11
  } seg_st_e;
endpackage

// File: rtl/ud6_seg_fsm.sv
module ud6_seg_fsm
  import ud6_pkg::*;
#(
  parameter bit START_LIVE = 1'b0
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    up_i,
  input  logic    dn_i,
  input  logic    peer_top_i,
  input  logic    peer_bot_i,
  output seg_st_e st_o,
  output logic    at_top_o,
  output logic    at_bot_o
);
  seg_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PARK: begin
        if (up_i && peer_top_i)      st_d = POS0;
        else if (dn_i && peer_bot_i) st_d = POS2;
      end
      POS0: begin
        if (up_i)      st_d = POS1;
        else if (dn_i) st_d = PARK;
      end
      POS1: begin
        if (up_i)      st_d = POS2;
        else if (dn_i) st_d = POS0;
      end
      POS2: begin
        if (up_i)      st_d = PARK;
        else if (dn_i) st_d = POS1;
      end
      default: st_d = PARK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= START_LIVE ? POS0 : PARK;
    else         st_q <= st_d;
  end

  assign st_o     = st_q;
  assign at_top_o = (st_q == POS2);
  assign at_bot_o = (st_q == POS0);
endmodule

// File: rtl/ud6_out_sel.sv
module ud6_out_sel
  import ud6_pkg::*;
(
  input  seg_st_e          lo_st_i,
  input  seg_st_e          hi_st_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] HI_BASE = CNT_W'(SEG_LEN);

  always_comb begin
    if (lo_st_i != PARK) count_o = {1'b0, lo_st_i};
    else                 count_o = HI_BASE + {1'b0, hi_st_i};
  end
endmodule

// File: rtl/ud6_counter.sv
module ud6_counter
  import ud6_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             down_i,
  output logic [CNT_W-1:0] count_o
);
  logic    step_up, step_dn;
  seg_st_e lo_st, hi_st;
  logic    lo_top, lo_bot, hi_top, hi_bot;

  // equal requests cancel to a hold
  assign step_up = up_i & ~down_i;
  assign step_dn = down_i & ~up_i;

  ud6_seg_fsm #(.START_LIVE(1'b1)) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(step_up), .dn_i(step_dn),
    .peer_top_i(hi_top), .peer_bot_i(hi_bot),
    .st_o(lo_st), .at_top_o(lo_top), .at_bot_o(lo_bot)
  );

  ud6_seg_fsm #(.START_LIVE(1'b0)) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(step_up), .dn_i(step_dn),
    .peer_top_i(lo_top), .peer_bot_i(lo_bot),
    .st_o(hi_st), .at_top_o(hi_top), .at_bot_o(hi_bot)
  );

  ud6_out_sel u_sel (
    .lo_st_i(lo_st), .hi_st_i(hi_st), .count_o(count_o)
  );
endmodule

// File: rtl/ud6_counter_chk.sv
module ud6_counter_chk
  import ud6_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up_i,
  input logic             down_i,
  input logic [CNT_W-1:0] count_o,
  input seg_st_e          lo_st,
  input seg_st_e          hi_st
);
  a_r5_one_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_st == PARK) != (hi_st == PARK));

  a_r8_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= 3'd5);

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !down_i) |=>
      count_o == (($past(count_o) == 3'd5) ? 3'd0 : $past(count_o) + 3'd1));

  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_i && !up_i) |=>
      count_o == (($past(count_o) == 3'd0) ? 3'd5 : $past(count_o) - 3'd1));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i == down_i) |=> $stable(count_o));

  a_r6_up_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_st == POS2 && up_i && !down_i) |=> (lo_st == PARK && hi_st == POS0));

  a_r7_down_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_st == POS0 && down_i && !up_i) |=> (hi_st == PARK && lo_st == POS2));
endmodule

bind ud6_counter ud6_counter_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .up_i(up_i), .down_i(down_i),
  .count_o(count_o), .lo_st(lo_st), .hi_st(hi_st)
);

// File: tb/tb_ud6_counter.sv
`timescale 1ns/1ps
module tb_ud6_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up_i = 1'b0;
  logic       down_i = 1'b0;
  logic [2:0] count_o;

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  ud6_counter dut (.clk_i(clk_i), .rst_ni(rst_ni), .up_i(up_i),
                   .down_i(down_i), .count_o(count_o));

  function automatic int ref_next(int c, bit u, bit d);
    if (u && !d) return (c == 5) ? 0 : c + 1;
    if (d && !u) return (c == 0) ? 5 : c - 1;
    return c;
  endfunction

  function automatic string tag_of(int c, bit u, bit d);
    if (u == d) return "R4";
    if (u) return (c == 2 || c == 5) ? "R6" : "R2";
    return (c == 3 || c == 0) ? "R7" : "R3";
  endfunction

  task automatic check(string tag, int exp);
    checks++;
    if (int'(count_o) != exp) begin
      fails++;
      $display("FAIL %s count_o=%0d expected=%0d", tag, count_o, exp);
    end
    if (count_o > 3'd5) begin
      fails++;
      $display("FAIL R8 count_o=%0d expected<=5", count_o);
    end
  endtask

  task automatic step(bit u, bit d);
    string t;
    @(negedge clk_i);
    up_i = u; down_i = d;
    t = tag_of(exp_cnt, u, d);
    exp_cnt = ref_next(exp_cnt, u, d);
    @(posedge clk_i); #1;
    check(t, exp_cnt);
  endtask

  initial begin
    int unsigned seed = 32'h5eed_0006;
    void'($urandom(seed));
    #23;
    check("R1", 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", 0);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0);   // up through 2->3, 5->0
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1);   // down through 0->5, 3->2
    // reverse right after each handoff
    while (exp_cnt != 2) step(1'b1, 1'b0);
    step(1'b1, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b0);
    while (exp_cnt != 0) step(1'b0, 1'b1);
    step(1'b0, 1'b1); step(1'b1, 1'b0); step(1'b0, 1'b1);
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 4)      step(1'b1, 1'b0);
      else if (r < 8) step(1'b0, 1'b1);
      else            step(r[0], r[0]);
    end
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog count_o=%0d expected=finished", count_o);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule